// File: doc/BRIEF.md
# Serial ADC Conversion Sequencer

This block sits on the host side of a four-wire serial link to a successive-approximation ADC. It runs one conversion per request. A request carries a 3-bit channel number, a bipolar flag and a single-ended flag. The block lowers chip select and shifts out a control byte, then two all-zero bytes. That is 24 SCLK periods in SPI mode 0, with MOSI changing only while SCLK is low and MISO sampled on each rising edge.

The byte that arrives during the control byte is dropped. The 16 bits that arrive during the two filler bytes hold the conversion code, with one pad bit in front and three pad bits behind. The block extracts the 12-bit code and presents it, together with a 16-bit copy that is sign-extended for bipolar conversions and zero-extended for unipolar ones. A done pulse marks the result.

The SCLK half period is a number of system clocks taken from a divider input when the request is accepted. A frame-length watchdog aborts any conversion whose chip-select-low time reaches a set limit. The default limit is sized for 120 µs at 100 MHz.

Top module: `adc_read_seq`

## Requirements
- R1: SCLK rests low whenever chip select is high. MOSI is updated only on SCLK falling edges or while SCLK is low. MISO is captured on SCLK rising edges.
- R2: With divider value D on `div_i` at acceptance (0 is taken as 1), every SCLK high phase lasts D system clocks. Every low phase lasts D clocks, except the two phases that follow a byte boundary, which last D + GAP_CYC clocks.
- R3: The first byte goes out MSB first. It is formed as follows: bit 7 is 1, bits 6:4 hold the channel, bit 3 holds `bipolar_i`, bit 2 holds `single_i`, and bits 1:0 are 11.
- R4: A completed frame holds chip select low for exactly 24 SCLK rising edges. The first edge comes after chip select falls, and chip select rises only after the last falling edge.
- R5: The second and third transmitted bytes are all zero.
- R6: Bits received during the first byte are discarded. Number the 16 bits received in bytes two and three 15 down to 0, with the first one received as bit 15. `result_o` then equals bits 14:3, whatever the values of the pad bits.
- R7: `result_sx_o[11:0]` equals `result_o`. Bits 15:12 copy `result_o[11]` when the conversion was bipolar, and are zero otherwise.
- R8: `busy_o` rises in the cycle after a start is accepted and stays high until `done_o`. `done_o` lasts one cycle, during which `busy_o` is low. A start that arrives while busy is dropped and never queued.
- R9: After chip select rises, at least 2·D system clocks pass before `done_o`, and so before the next frame can begin.
- R10: If chip select has been low for TMO_CYC clocks and the frame is not complete, the block raises chip select, ends the frame, and pulses `done_o` with `err_o` = 1 and `result_o` unchanged. A frame that completes normally reports `err_o` = 0.
- R11: After reset: chip select high, SCLK low, MOSI low, busy, done and error low, and both results zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Conversion request, taken when idle |
| chan_i | input | 3 | Channel number for the request |
| bipolar_i | input | 1 | 1 selects bipolar (two's complement) coding |
| single_i | input | 1 | 1 selects single-ended input, 0 differential |
| div_i | input | DIV_W | SCLK half period in system clocks |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle result strobe |
| err_o | output | 1 | Last conversion ended by the frame watchdog |
| result_o | output | 12 | Conversion code |
| result_sx_o | output | 16 | Code widened by sign or zero extension |
| cs_n_o | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the ADC |
| miso_i | input | 1 | Serial data from the ADC |

## Verification
The bench sweeps every channel and both mode flags over several divider values, including 0. A slave model returns codes whose pad bits are deliberately set to ones, so extracting the code from the wrong window, or keeping the discarded first byte, produces wrong codes. Each SCLK phase is timed, so that a divider off by one or a missing byte gap is caught. The extremes 0x000, 0x7FF, 0x800 and 0xFFF show whether the widened result takes its sign from the right bit. Further tests cover a start pulsed in mid-frame, which a queuing design would turn into a second frame, and a slow divider that trips the watchdog, where a faulty abort would keep chip select low or overwrite the previous result.

// File: rtl/adc_read_seq_pkg.sv
package adc_read_seq_pkg;

    localparam int FRAME_BITS = 24;
    localparam int BYTE_BITS  = 8;
    localparam int RES_W      = 12;
    localparam int RX_W       = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_GAP,
        ST_COOL
    } seq_state_e;

    typedef struct packed {
        logic [2:0] chan;
        logic       bipolar;
        logic       single;
    } conv_req_t;

    // start bit, channel, coding, input type, external-clock selection
    function automatic logic [BYTE_BITS-1:0] ctrl_byte(input conv_req_t r);
        return {1'b1, r.chan, r.bipolar, r.single, 2'b11};
    endfunction

    function automatic logic [RES_W-1:0] pick_code(input logic [RX_W-1:0] rx);
        return rx[RX_W-2:3];
    endfunction

    function automatic logic [RX_W-1:0] widen(input logic [RES_W-1:0] v, input logic bip);
        return bip ? {{(RX_W-RES_W){v[RES_W-1]}}, v} : {{(RX_W-RES_W){1'b0}}, v};
    endfunction

endpackage

// File: rtl/adc_read_seq_tick.sv
module adc_read_seq_tick #(
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic [CW-1:0] lim,
    output logic          tick
);
    logic [CW-1:0] cnt;

    assign tick = (cnt == lim);

    always_ff @(posedge clk) begin
        if (rst || clr || tick) cnt <= '0;
        else                    cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/adc_read_seq_timer.sv
module adc_read_seq_timer #(
    parameter int LIMIT = 12000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int TW = $clog2(LIMIT + 1);
    logic [TW-1:0] cnt;

    assign expired = run && (cnt == TW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || !run)  cnt <= '0;
        else if (!expired) cnt <= cnt + TW'(1);
    end
endmodule

// File: rtl/adc_read_seq_shift.sv
module adc_read_seq_shift
    import adc_read_seq_pkg::*;
#(
    parameter int TX_W = FRAME_BITS,
    parameter int RW   = RX_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic                 flush,
    input  logic [BYTE_BITS-1:0] ctrl,
    input  logic                 shift_tx,
    input  logic                 cap,
    input  logic                 miso,
    output logic                 mosi,
    output logic [RW-1:0]        rx
);
    logic [TX_W-1:0] tx;

    assign mosi = tx[TX_W-1];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            tx <= '0;
        end else if (load) begin
            tx <= {ctrl, {(TX_W-BYTE_BITS){1'b0}}};
        end else if (shift_tx) begin
            tx <= {tx[TX_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst || load) rx <= '0;
        else if (cap)    rx <= {rx[RW-2:0], miso};
    end
endmodule

// File: rtl/adc_read_seq.sv
module adc_read_seq
    import adc_read_seq_pkg::*;
#(
    parameter int DIV_W   = 10,
    parameter int GAP_CYC = 2,
    parameter int TMO_CYC = 12000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [2:0]       chan_i,
    input  logic             bipolar_i,
    input  logic             single_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o,
    output logic [11:0]      result_o,
    output logic [15:0]      result_sx_o,
    output logic             cs_n_o,
    output logic             sclk_o,
    output logic             mosi_o,
    input  logic             miso_i
);
    localparam int CW      = DIV_W + 1;
    localparam int BIT_W   = $clog2(FRAME_BITS);
    localparam int GAP_LIM = (GAP_CYC > 1) ? GAP_CYC - 1 : 0;

    seq_state_e        state;
    logic [BIT_W-1:0]  bit_q;
    logic [DIV_W-1:0]  div_q;
    logic              bip_q;
    logic              err_q;
    logic              done_q;
    logic              cs_n_q;
    logic              sclk_q;
    logic [RES_W-1:0]  res_q;
    logic [RX_W-1:0]   sx_q;
    logic [CW-1:0]     lim;
    logic              tick, expired, in_frame, abort, accept;
    logic              last_bit, byte_end, cap, shift_tx;
    logic [RX_W-1:0]   rx;
    conv_req_t         req;

    assign req      = '{chan: chan_i, bipolar: bipolar_i, single: single_i};
    assign in_frame = (state == ST_LOW) || (state == ST_HIGH) || (state == ST_GAP);
    assign abort    = in_frame && expired;
    assign accept   = (state == ST_IDLE) && start_i;
    assign last_bit = (bit_q == BIT_W'(FRAME_BITS - 1));
    assign byte_end = (bit_q[2:0] == 3'd7);
    assign cap      = (state == ST_LOW) && tick && !abort && (bit_q >= BIT_W'(BYTE_BITS));
    assign shift_tx = (state == ST_HIGH) && tick && !abort && !last_bit;

    always_comb begin
        case (state)
            ST_GAP:  lim = CW'(GAP_LIM);
            ST_COOL: lim = {div_q, 1'b0} - CW'(1);
            default: lim = {1'b0, div_q} - CW'(1);
        endcase
    end

    adc_read_seq_tick #(.CW(CW)) u_tick (
        .clk (clk),
        .rst (rst),
        .clr ((state == ST_IDLE) || abort),
        .lim (lim),
        .tick(tick)
    );

    adc_read_seq_timer #(.LIMIT(TMO_CYC)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (in_frame),
        .expired(expired)
    );

    adc_read_seq_shift u_shift (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .flush   (abort),
        .ctrl    (ctrl_byte(req)),
        .shift_tx(shift_tx),
        .cap     (cap),
        .miso    (miso_i),
        .mosi    (mosi_o),
        .rx      (rx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            bit_q  <= '0;
            div_q  <= DIV_W'(1);
            bip_q  <= 1'b0;
            err_q  <= 1'b0;
            done_q <= 1'b0;
            cs_n_q <= 1'b1;
            sclk_q <= 1'b0;
            res_q  <= '0;
            sx_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (abort) begin
                cs_n_q <= 1'b1;
                sclk_q <= 1'b0;
                err_q  <= 1'b1;
                state  <= ST_COOL;
            end else begin
                case (state)
                    ST_IDLE: if (start_i) begin
                        div_q  <= (div_i == '0) ? DIV_W'(1) : div_i;
                        bip_q  <= bipolar_i;
                        err_q  <= 1'b0;
                        bit_q  <= '0;
                        cs_n_q <= 1'b0;
                        sclk_q <= 1'b0;
                        state  <= ST_LOW;
                    end
                    ST_LOW: if (tick) begin
                        sclk_q <= 1'b1;
                        state  <= ST_HIGH;
                    end
                    ST_HIGH: if (tick) begin
                        sclk_q <= 1'b0;
                        if (last_bit) begin
                            cs_n_q <= 1'b1;
                            state  <= ST_COOL;
                        end else begin
                            bit_q <= bit_q + BIT_W'(1);
                            state <= byte_end ? ST_GAP : ST_LOW;
                        end
                    end
                    ST_GAP: if (tick) state <= ST_LOW;
                    ST_COOL: if (tick) begin
                        state  <= ST_IDLE;
                        done_q <= 1'b1;
                        if (!err_q) begin
                            res_q <= pick_code(rx);
                            sx_q  <= widen(pick_code(rx), bip_q);
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assign busy_o      = (state != ST_IDLE);
    assign done_o      = done_q;
    assign err_o       = err_q;
    assign result_o    = res_q;
    assign result_sx_o = sx_q;
    assign cs_n_o      = cs_n_q;
    assign sclk_o      = sclk_q;
endmodule

// File: rtl/adc_read_seq_chk.sv
module adc_read_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy_o,
    input logic        done_o,
    input logic [11:0] result_o,
    input logic [15:0] result_sx_o,
    input logic        cs_n_o,
    input logic        sclk_o,
    input logic        mosi_o
);
    AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (rst)
        cs_n_o |-> !sclk_o); // R1
    AST_MOSI_AT_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk_o) |-> $stable(mosi_o)); // R1
    AST_MOSI_IN_HIGH: assert property (@(posedge clk) disable iff (rst)
        (sclk_o && $past(sclk_o)) |-> $stable(mosi_o)); // R1
    AST_CS_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> cs_n_o); // R4
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R8
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o); // R8
    AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> done_o); // R8
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(result_o)); // R6
    AST_SX_LOW_MATCH: assert property (@(posedge clk) disable iff (rst)
        result_sx_o[11:0] == result_o); // R7
    AST_SX_UPPER: assert property (@(posedge clk) disable iff (rst)
        (result_sx_o[15:12] == 4'h0) || (result_sx_o[15:12] == {4{result_o[11]}})); // R7
endmodule

bind adc_read_seq adc_read_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .result_o   (result_o),
    .result_sx_o(result_sx_o),
    .cs_n_o     (cs_n_o),
    .sclk_o     (sclk_o),
    .mosi_o     (mosi_o)
);

// File: tb/sim_adc_read_seq.sv
`timescale 1ns/1ps
module sim_adc_read_seq;
    localparam int DIV_W = 10;
    localparam int GAP   = 2;
    localparam int TMO   = 1000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic             start_i = 1'b0;
    logic [2:0]       chan_i = '0;
    logic             bipolar_i = 1'b0;
    logic             single_i = 1'b0;
    logic [DIV_W-1:0] div_i = '0;
    logic             busy_o, done_o, err_o, cs_n_o, sclk_o, mosi_o;
    logic [11:0]      result_o;
    logic [15:0]      result_sx_o;
    logic             miso = 1'b0;

    adc_read_seq #(.DIV_W(DIV_W), .GAP_CYC(GAP), .TMO_CYC(TMO)) u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .chan_i(chan_i),
        .bipolar_i(bipolar_i), .single_i(single_i), .div_i(div_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
        .result_o(result_o), .result_sx_o(result_sx_o),
        .cs_n_o(cs_n_o), .sclk_o(sclk_o), .mosi_o(mosi_o), .miso_i(miso)
    );

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    int exp_div = 1;
    bit finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // slave model and bus monitors
    logic [23:0] resp = '0;
    logic [23:0] sh = '0;
    logic [23:0] mo = '0;
    int rises = 0;
    int rise_cyc = 0, fall_cyc = 0, fell_cyc = 0, cs_rise_cyc = 0;
    int cs_low_len = 0, cs_gap = 0;
    int bad_hi = 0, bad_lo = 0;

    always @(negedge cs_n_o) begin
        fell_cyc = cyc;
        cs_gap   = cyc - cs_rise_cyc;
        sh       = resp;
        miso     = resp[23];
    end

    always @(posedge cs_n_o) begin
        cs_rise_cyc = cyc;
        cs_low_len  = cyc - fell_cyc;
    end

    always @(posedge sclk_o) begin
        int lo_ref;
        if (fell_cyc > rise_cyc) begin
            rises  = 0;
            mo     = '0;
            lo_ref = fell_cyc;
        end else begin
            lo_ref = fall_cyc;
        end
        rises = rises + 1;
        mo    = {mo[22:0], mosi_o};
        if ((rises == 9 || rises == 17) ? (cyc - lo_ref != exp_div + GAP)
                                        : (cyc - lo_ref != exp_div))
            bad_lo = bad_lo + 1;
        rise_cyc = cyc;
    end

    always @(negedge sclk_o) begin
        if (cyc - rise_cyc != exp_div) bad_hi = bad_hi + 1;
        fall_cyc = cyc;
        sh   = {sh[22:0], 1'b0};
        miso = sh[23];
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        nchk = nchk + 1;
        if (!ok) begin
            nfail = nfail + 1;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] ch, input bit bip, input bit sgl,
                         input int d, input logic [11:0] code, input logic [3:0] pad);
        exp_div = (d == 0) ? 1 : d;
        resp = {8'hA5 ^ code[7:0], pad[3], code, pad[2:0]};
        @(negedge clk);
        chan_i = ch; bipolar_i = bip; single_i = sgl; div_i = DIV_W'(d);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done();
        while (!done_o) @(negedge clk);
    endtask

    task automatic conv(input logic [2:0] ch, input bit bip, input bit sgl,
                        input int d, input logic [11:0] code, input logic [3:0] pad);
        int hi0, lo0;
        logic [7:0] ctl;
        logic [15:0] sx;
        hi0 = bad_hi; lo0 = bad_lo;
        issue(ch, bip, sgl, d, code, pad);
        check(busy_o == 1'b1, "R8", "busy after accept", busy_o, 1);
        wait_done();
        ctl = {1'b1, ch, bip, sgl, 2'b11};
        sx  = bip ? {{4{code[11]}}, code} : {4'h0, code};
        check(mo[23:16] == ctl, "R3", "control byte", mo[23:16], ctl);
        check(mo[15:0] == 16'h0, "R5", "filler bytes", mo[15:0], 0);
        check(rises == 24, "R4", "sclk rising edges", rises, 24);
        check(result_o == code, "R6", "result code", result_o, code);
        check(result_sx_o == sx, "R7", "widened result", result_sx_o, sx);
        check(err_o == 1'b0, "R10", "error on normal frame", err_o, 0);
        check(busy_o == 1'b0, "R8", "busy during done", busy_o, 0);
        check(bad_hi == hi0, "R2", "sclk high phase errors", bad_hi - hi0, 0);
        check(bad_lo == lo0, "R2", "sclk low phase errors", bad_lo - lo0, 0);
        check(cyc - cs_rise_cyc >= 2 * exp_div, "R9", "cs high before done",
              cyc - cs_rise_cyc, 2 * exp_div);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nchk = nchk + 1;
            nfail = nfail + 1;
            $display("FAIL R8 watchdog: actual hung expected completion");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        logic [11:0] keep;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(cs_n_o == 1'b1, "R11", "reset cs_n", cs_n_o, 1);
        check(sclk_o == 1'b0, "R11", "reset sclk", sclk_o, 0);
        check(mosi_o == 1'b0, "R11", "reset mosi", mosi_o, 0);
        check(busy_o == 1'b0 && done_o == 1'b0 && err_o == 1'b0, "R11", "reset flags",
              {busy_o, done_o, err_o}, 0);
        check(result_o == 12'h0 && result_sx_o == 16'h0, "R11", "reset result", result_o, 0);

        // sweep over channel, coding and input type
        for (int ch = 0; ch < 8; ch++)
            for (int b = 0; b < 2; b++)
                for (int s = 0; s < 2; s++)
                    conv(3'(ch), b[0], s[0], 1 + ((ch + 2 * b + s) % 4),
                         12'((ch * 517 + b * 1234 + s * 77 + 12'h801) & 12'hFFF),
                         4'((ch * 3 + b * 5 + s) & 15));

        // code extremes with pad bits set against the code
        conv(3'd7, 1'b1, 1'b1, 2, 12'h800, 4'hF);
        conv(3'd0, 1'b1, 1'b0, 3, 12'h7FF, 4'hF);
        conv(3'd5, 1'b0, 1'b1, 1, 12'hFFF, 4'h0);
        conv(3'd3, 1'b1, 1'b1, 2, 12'hFFF, 4'hF);
        conv(3'd1, 1'b0, 1'b0, 0, 12'h000, 4'hF);   // divider 0 acts as 1

        // start pulsed in mid-frame is dropped
        issue(3'd2, 1'b0, 1'b1, 2, 12'h3C5, 4'h9);
        while (rises < 5 || cs_n_o) @(negedge clk);
        chan_i = 3'd5; bipolar_i = 1'b1; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done();
        check(mo[23:16] == 8'b1_010_0_1_11, "R8", "control byte after busy start",
              mo[23:16], 8'b1_010_0_1_11);
        check(result_o == 12'h3C5, "R8", "result after busy start", result_o, 12'h3C5);
        begin
            int hi_seen = 0;
            repeat (30) begin
                @(negedge clk);
                if (!cs_n_o || busy_o) hi_seen++;
            end
            check(hi_seen == 0, "R8", "queued frame after busy start", hi_seen, 0);
        end

        // back-to-back frames keep chip select high long enough
        conv(3'd6, 1'b0, 1'b1, 4, 12'h123, 4'h6);
        conv(3'd4, 1'b1, 1'b0, 4, 12'hABC, 4'h3);
        check(cs_gap >= 8, "R9", "cs high gap between frames", cs_gap, 8);

        // watchdog abort with a slow divider
        keep = result_o;
        issue(3'd1, 1'b0, 1'b1, 30, 12'h555, 4'h0);
        wait_done();
        check(err_o == 1'b1, "R10", "timeout error flag", err_o, 1);
        check(result_o == keep, "R10", "result kept on timeout", result_o, keep);
        check(cs_low_len == TMO, "R10", "cs low length on timeout", cs_low_len, TMO);
        check(rises < 24, "R10", "frame cut short", rises, 23);
        check(cs_n_o == 1'b1 && sclk_o == 1'b0, "R1", "lines parked after abort",
              {cs_n_o, sclk_o}, 2);

        // recovery after an abort
        conv(3'd2, 1'b1, 1'b1, 3, 12'h9A6, 4'hA);

        finished = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule